// File: doc/BRIEF.md
# PIO Read Strobe Sequencer

This block is a synchronous host-side engine that reads 16-bit words from a memory-mapped peripheral over an asynchronous strobe bus. An internal client raises a request with a 7-bit word address. The sequencer takes the request only while it is idle. It then presents the address, pulls chip select and read enable low together, and holds them low long enough for the peripheral's data to become valid. At the edge where both strobes are released it samples the data bus and returns the word with a one-cycle done pulse. The strobes then stay high for a recovery gap before the next request is taken.

All bus timing limits are parameters in nanoseconds. They are converted to system-clock counts by rounding up, using the clock period parameter. The low time is the larger of the minimum strobe width and the data-valid delay plus one capture cycle. The recovery time is the larger of the minimum high gap and whatever remains of the minimum cycle time once the low time is spent. With the defaults (4 ns clock), the strobes stay low for 9 cycles and high for at least 4 cycles. One address setup cycle comes before each low phase. An accepted request therefore occupies 14 cycles from acceptance to the next ready.

Top module: `pio_rd_seq`

## Requirements
- R1: While reset is asserted, and right after it, bus_cs_no and bus_rd_no are 1, bus_addr_o is 0, req_ready_o is 1, rsp_valid_o is 0 and rsp_data_o is 0. A reset in the middle of a read abandons the read.
- R2: req_ready_o is 1 only while idle. A request is accepted at a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 for 14 cycles with the default parameters.
- R3: From the cycle after acceptance, bus_addr_o equals the accepted address. It keeps that value until the next acceptance, so it does not change while the strobes are low.
- R4: The address is driven for one full cycle with both strobes high before the strobes fall.
- R5: bus_cs_no and bus_rd_no are always equal. Both fall on the same edge and both rise on the same edge.
- R6: Each read holds the strobes low for exactly ACT_CYC cycles. ACT_CYC = max(ceil(T_ACT_NS/CLK_PERIOD_NS), ceil(T_DV_NS/CLK_PERIOD_NS)+1), which is 9 with the defaults.
- R7: After a read, the strobes stay high for at least IDLE_CYC cycles plus the setup cycle before the next fall. IDLE_CYC = max(ceil(T_GAP_NS/CLK_PERIOD_NS), ceil(T_CYC_NS/CLK_PERIOD_NS) - ACT_CYC, 1), which is 4 with the defaults.
- R8: rsp_data_o takes the value bus_data_i has at the clock edge where the strobes rise. It holds that value until the next read completes.
- R9: rsp_valid_o is 1 for exactly one cycle per completed read, in the cycle right after the strobes rise.
- R10: A request presented while req_ready_o is 0 is ignored. The number of strobe low phases equals the number of accepted requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read request |
| req_addr_i | input | 7 | Word address of the request |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| rsp_valid_o | output | 1 | One-cycle done pulse |
| rsp_data_o | output | 16 | Captured read word |
| bus_addr_o | output | 7 | Word address to the peripheral |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read enable, active low |
| bus_data_i | input | 16 | Peripheral data bus |

## Verification
The sequencer state and its timer appear directly on the strobes and on ready. A wrong state or a wrong count therefore shows as a strobe edge or a ready edge at least one cycle off from the model, and it is reported on that cycle. A capture on the wrong edge shows as a mismatched word in the done cycle, because the bench changes the data bus every cycle. A spurious bus cycle shows up in the final count of strobe falls against accepted requests.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_GAP} rd_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int act_cycles(input int clk_ns, input int act_ns, input int dv_ns);
    return max2(ceil_div(act_ns, clk_ns), ceil_div(dv_ns, clk_ns) + 1);
  endfunction

  function automatic int idle_cycles(input int clk_ns, input int gap_ns, input int cyc_ns,
                                     input int act_cyc);
    return max2(max2(ceil_div(gap_ns, clk_ns), ceil_div(cyc_ns, clk_ns) - act_cyc), 1);
  endfunction
endpackage

// File: rtl/pio_rd_timer.sv
module pio_rd_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pio_rd_ctrl.sv
module pio_rd_ctrl
  import pio_rd_pkg::*;
#(
  parameter int AW       = 7,
  parameter int CW       = 4,
  parameter int ACT_CYC  = 9,
  parameter int IDLE_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          expired_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          capture_o,
  output logic          ready_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          strobe_no
);
  localparam logic [CW-1:0] ActLoad  = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] IdleLoad = CW'(IDLE_CYC - 1);

  rd_state_e state_q, state_d;
  logic      accept;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d    = ST_ACTIVE;
        load_o     = 1'b1;
        load_val_o = ActLoad;
      end
      ST_ACTIVE: if (expired_i) begin
        state_d    = ST_GAP;
        load_o     = 1'b1;
        load_val_o = IdleLoad;
        capture_o  = 1'b1;
      end
      ST_GAP:    if (expired_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bus_addr_o <= '0;
      strobe_no  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) bus_addr_o <= req_addr_i;
      // both strobes share one flop: they move on the same edge
      strobe_no <= (state_d != ST_ACTIVE);
    end
  end
endmodule

// File: rtl/pio_rd_capture.sv
module pio_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_data_o <= bus_data_i;
    end
  end
endmodule

// File: rtl/pio_rd_seq.sv
module pio_rd_seq
  import pio_rd_pkg::*;
#(
  parameter int AW            = 7,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_ACT_NS      = 32,
  parameter int T_GAP_NS      = 13,
  parameter int T_CYC_NS      = 45,
  parameter int T_DV_NS       = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_cs_no,
  output logic          bus_rd_no,
  input  logic [DW-1:0] bus_data_i
);
  localparam int ACT_CYC  = act_cycles(CLK_PERIOD_NS, T_ACT_NS, T_DV_NS);
  localparam int IDLE_CYC = idle_cycles(CLK_PERIOD_NS, T_GAP_NS, T_CYC_NS, ACT_CYC);
  localparam int CW       = $clog2(max2(ACT_CYC, IDLE_CYC) + 1);

  logic          load, expired, capture, strobe_n;
  logic [CW-1:0] load_val;

  pio_rd_ctrl #(
    .AW(AW), .CW(CW), .ACT_CYC(ACT_CYC), .IDLE_CYC(IDLE_CYC)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_addr_i (req_addr_i),
    .expired_i  (expired),
    .load_o     (load),
    .load_val_o (load_val),
    .capture_o  (capture),
    .ready_o    (req_ready_o),
    .bus_addr_o (bus_addr_o),
    .strobe_no  (strobe_n)
  );

  pio_rd_timer #(.CW(CW)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .expired_o (expired)
  );

  pio_rd_capture #(.DW(DW)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .bus_data_i (bus_data_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_data_o)
  );

  assign bus_cs_no = strobe_n;
  assign bus_rd_no = strobe_n;
endmodule

// File: rtl/pio_rd_seq_chk.sv
module pio_rd_seq_chk
  import pio_rd_pkg::*;
#(
  parameter int AW            = 7,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_ACT_NS      = 32,
  parameter int T_GAP_NS      = 13,
  parameter int T_CYC_NS      = 45,
  parameter int T_DV_NS       = 30
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [DW-1:0] rsp_data_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_cs_no,
  input logic          bus_rd_no,
  input logic [DW-1:0] bus_data_i
);
  localparam int ACT_CYC  = act_cycles(CLK_PERIOD_NS, T_ACT_NS, T_DV_NS);
  localparam int IDLE_CYC = idle_cycles(CLK_PERIOD_NS, T_GAP_NS, T_CYC_NS, ACT_CYC);

  logic [7:0] low_cnt, high_cnt;
  logic       seen_read;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt   <= '0;
      high_cnt  <= '0;
      seen_read <= 1'b0;
    end else begin
      low_cnt  <= bus_cs_no ? 8'd0 : low_cnt + 8'd1;
      high_cnt <= !bus_cs_no ? 8'd0 : ((high_cnt == 8'hff) ? high_cnt : high_cnt + 8'd1);
      if (!bus_cs_no) seen_read <= 1'b1;
    end
  end

  a_r5_strobes_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_no == bus_rd_no);

  a_r2_idle_strobes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> bus_cs_no);

  a_r3_addr_held_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cs_no |-> $stable(bus_addr_o));

  a_r4_addr_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_no) |-> $stable(bus_addr_o));

  a_r6_active_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_cs_no) |-> (low_cnt == 8'(ACT_CYC)));

  a_r7_recovery_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_cs_no) && seen_read) |-> (high_cnt >= 8'(IDLE_CYC + 1)));

  a_r9_done_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(bus_cs_no));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind pio_rd_seq pio_rd_seq_chk #(
  .AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_ACT_NS(T_ACT_NS),
  .T_GAP_NS(T_GAP_NS), .T_CYC_NS(T_CYC_NS), .T_DV_NS(T_DV_NS)
) i_pio_rd_seq_chk (.*);

// File: tb/test_pio_rd_seq.sv
module test_pio_rd_seq;
  // timing derived here from the nanosecond figures, 4 ns clock
  localparam int ACT  = 9;   // max(ceil(32/4)=8, ceil(30/4)+1=9)
  localparam int IDLE = 4;   // max(ceil(13/4)=4, ceil(45/4)-9=3)
  localparam int BUSY = 1 + ACT + IDLE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [6:0]  req_addr = '0;
  logic        req_ready, rsp_valid, cs_n, rd_n;
  logic [15:0] rsp_data, bus_data = 16'h0;
  logic [6:0]  bus_addr;

  always #2 clk = ~clk;

  pio_rd_seq i_pio_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .bus_addr_o(bus_addr), .bus_cs_no(cs_n), .bus_rd_no(rd_n), .bus_data_i(bus_data)
  );

  int n_tests = 0, n_fail = 0, starts = 0, falls = 0, cyc = 0, mode = 0;
  int t = -1;
  logic [6:0]  m_addr = '0;
  logic [15:0] m_data = '0;
  logic        m_valid = 1'b0;
  logic        prev_cs = 1'b1;
  logic [15:0] lfsr = 16'hace1;
  bit          finished = 0;

  // behavioural reference: t counts edges since acceptance, -1 when idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = -1; m_addr = '0; m_data = '0; m_valid = 1'b0;
    end else begin
      m_valid = 1'b0;
      if (t < 0) begin
        if (req_valid) begin t = 0; m_addr = req_addr; end
      end else begin
        if (t == ACT) begin m_data = bus_data; m_valid = 1'b1; end
        t++;
        if (t == 1) starts++;
        if (t == BUSY) t = -1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!finished) begin
      logic exp_sn;
      cyc++;
      exp_sn = !(t >= 1 && t <= ACT);
      if (!rst_n) chk("R1 reset strobes", {31'd0, cs_n}, 32'd1);
      chk("R5 rd equals cs", {31'd0, rd_n}, {31'd0, cs_n});
      chk("R6/R7 strobe level", {31'd0, cs_n}, {31'd0, exp_sn});
      chk("R4 setup cycle", {31'd0, (t == 0) ? cs_n : 1'b1}, 32'd1);
      chk("R2 ready", {31'd0, req_ready}, {31'd0, t < 0});
      chk("R3 bus address", {25'd0, bus_addr}, {25'd0, m_addr});
      chk("R9 done pulse", {31'd0, rsp_valid}, {31'd0, m_valid});
      chk("R8 captured word", {16'd0, rsp_data}, {16'd0, m_data});
      if (prev_cs && !cs_n) falls++;
      prev_cs = cs_n;
    end
  end

  // stimulus: inputs change only on the falling edge
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_data <= lfsr ^ {9'd0, cyc[6:0]};
    case (mode)
      0: begin req_valid <= (lfsr[2:0] == 3'd0); req_addr <= lfsr[9:3]; end
      1: begin req_valid <= 1'b1; req_addr <= lfsr[12:6]; end
      2: begin req_valid <= 1'b1; req_addr <= lfsr[0] ? 7'h7f : 7'h00; end
      default: begin req_valid <= 1'b0; req_addr <= lfsr[6:0]; end
    endcase
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 reset addr", {25'd0, bus_addr}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset done", {15'd0, rsp_valid, rsp_data}, 32'd0);
    rst_n = 1'b1;
    mode = 0; repeat (600) @(negedge clk);
    mode = 1; repeat (600) @(negedge clk);
    mode = 2; repeat (400) @(negedge clk);
    // reset in the middle of a low phase
    mode = 1;
    wait (cs_n == 1'b0);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 abort strobes", {31'd0, cs_n}, 32'd1);
    chk("R1 abort addr", {25'd0, bus_addr}, 32'd0);
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (300) @(negedge clk);
    mode = 3; repeat (BUSY + 2) @(negedge clk);
    chk("R10 idle after drain", {31'd0, req_ready}, 32'd1);
    chk("R10 falls vs accepts", falls, starts);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at cyc %0d: actual hung expected done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule